// File: doc/BRIEF.md
# Multi-Rail Power Fault Supervisor

This block watches four supply rails through digitized comparator flags and decides how the supply system reacts to each fault. Rail 1 reports over-voltage and over-current. Rails 2, 3 and 4 report under-voltage. The block chooses between a permanent shutdown and a retry, and the choice depends on which rail failed.

An over-voltage on rail 1 or an under-voltage on rail 4 shuts the system down at once. An over-current on rail 1, or an under-voltage on rail 2 or rail 3, starts a retry. Rails 1 to 3 are inhibited and the soft-start capacitors are discharged. When the rail 2/4 ramp group reports that it is discharged, the retry latch is released and the rails ramp up again.

Two saturating counters track consecutive retries: one for rail-1 over-current and one for the linear-rail under-voltages. The third consecutive fault on either counter turns the retry into a permanent shutdown. Only the power-on reset can clear that shutdown.

Under-voltage flags are ignored while their ramp group is still rising:
- Rail 3 belongs to ramp group A.
- Rails 2 and 4 belong to ramp group B.

Top module: `rail_fault_supervisor`

## Requirements
- R1: A rail-1 over-voltage flag sets `shutdown_o` and `inhibit_o` and takes no retry path. The outputs change on the third rising clock edge after the flag is applied (two synchronizer stages plus one state register). All fault reactions share this three-edge latency.
- R2: A rail-4 under-voltage sets `shutdown_o` only while `grp_b_up_i` is high. While `grp_b_up_i` is low the flag has no effect on any output.
- R3: A rising over-current flag on rail 1 sets `oc_retry_o`. It raises `inhibit_o` and `discharge_o`, and it increments `oc_count_o` by one.
- R4: A rising rail-2 or rail-3 under-voltage sets `uv_retry_o` and increments `uv_count_o`. Rail 2 is ignored while `grp_b_up_i` is low. Rail 3 is ignored while `grp_a_up_i` is low.
- R5: The third consecutive fault on either counter sets `shutdown_o` in the same cycle that the counter reaches 3. The counter saturates at 3.
- R6: A retry latch clears only when `grp_b_low_i` is seen high. `inhibit_o` and `discharge_o` then fall, unless a shutdown is latched.
- R7: Both counters return to 0 when the start-up is healthy. Healthy means both ramp-complete flags are high, no retry or shutdown is latched, and no qualified fault flag is present.
- R8: Once `shutdown_o` is set, it and `inhibit_o` stay high whatever the other inputs do.
- R9: `por_i` high clears the shutdown, both retry latches and both counters.
- R10: A fault flag held high for many cycles counts as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ov1_i | input | 1 | Rail 1 over-voltage flag |
| oc1_i | input | 1 | Rail 1 over-current flag |
| uv2_i | input | 1 | Rail 2 under-voltage flag |
| uv3_i | input | 1 | Rail 3 under-voltage flag |
| uv4_i | input | 1 | Rail 4 under-voltage flag |
| grp_a_up_i | input | 1 | Ramp group A (rails 1, 3) fully charged |
| grp_b_up_i | input | 1 | Ramp group B (rails 2, 4) fully charged |
| grp_b_low_i | input | 1 | Ramp group B capacitor discharged |
| inhibit_o | output | 1 | Disable rails 1 to 3 |
| discharge_o | output | 1 | Request soft-start discharge |
| shutdown_o | output | 1 | Permanent fault latched |
| oc_retry_o | output | 1 | Over-current retry latch |
| uv_retry_o | output | 1 | Under-voltage retry latch |
| oc_count_o | output | 2 | Consecutive over-current count |
| uv_count_o | output | 2 | Consecutive under-voltage count |

## Verification
Each fault class is checked at the ports, where it shows up as a distinct combination of retry latch, counter value and shutdown three clock edges after the flag is applied. A counter that misses a clear, double-counts a held flag, or steps by the wrong amount appears immediately on `oc_count_o` or `uv_count_o`. The same error later shows as a shutdown one retry too early or too late. A mask wired to the wrong ramp group shows up as a retry or shutdown that fires while the bench keeps that group low.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 2,
  parameter int MAX_TRIES = 3
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             ov1_i,
  input  logic             oc1_i,
  input  logic             uv2_i,
  input  logic             uv3_i,
  input  logic             uv4_i,
  input  logic             grp_a_up_i,
  input  logic             grp_b_up_i,
  input  logic             grp_b_low_i,
  output logic             inhibit_o,
  output logic             discharge_o,
  output logic             shutdown_o,
  output logic             oc_retry_o,
  output logic             uv_retry_o,
  output logic [CNT_W-1:0] oc_count_o,
  output logic [CNT_W-1:0] uv_count_o
);
  localparam int NIN = 8;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRIES - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(MAX_TRIES);

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] s;

  assign raw = {grp_b_low_i, grp_b_up_i, grp_a_up_i, uv4_i, uv3_i, uv2_i, oc1_i, ov1_i};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) sync_q[g] <= '0;
        else       sync_q[g] <= (g == 0) ? raw : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign s = sync_q[SYNC_STAGES-1];

  logic ov_s, oc_s, a_up, b_up, b_low, uv2_q, uv3_q, uv4_q, uv23_q;
  assign ov_s   = s[0];
  assign oc_s   = s[1];
  assign a_up   = s[5];
  assign b_up   = s[6];
  assign b_low  = s[7];
  assign uv2_q  = s[2] & b_up;
  assign uv3_q  = s[3] & a_up;
  assign uv4_q  = s[4] & b_up;
  assign uv23_q = uv2_q | uv3_q;

  logic oc_prev, uv_prev, oc_ev, uv_ev;
  logic oc_ret_q, uv_ret_q, shut_q;
  logic [CNT_W-1:0] oc_cnt_q, uv_cnt_q;
  logic healthy, shut_set;

  assign oc_ev = oc_s & ~oc_prev;
  assign uv_ev = uv23_q & ~uv_prev;

  assign healthy = a_up & b_up & ~oc_ret_q & ~uv_ret_q & ~shut_q &
                   ~ov_s & ~oc_s & ~uv23_q & ~uv4_q;

  assign shut_set = ov_s | uv4_q | (oc_ev && oc_cnt_q >= LAST) | (uv_ev && uv_cnt_q >= LAST);

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      oc_prev  <= 1'b0;
      uv_prev  <= 1'b0;
      oc_ret_q <= 1'b0;
      uv_ret_q <= 1'b0;
      shut_q   <= 1'b0;
      oc_cnt_q <= '0;
      uv_cnt_q <= '0;
    end else begin
      oc_prev <= oc_s;
      uv_prev <= uv23_q;
      if (shut_set) shut_q <= 1'b1;

      if (oc_ev)      oc_ret_q <= 1'b1;
      else if (b_low) oc_ret_q <= 1'b0;
      if (uv_ev)      uv_ret_q <= 1'b1;
      else if (b_low) uv_ret_q <= 1'b0;

      if (oc_ev)        oc_cnt_q <= (oc_cnt_q == TOP) ? TOP : oc_cnt_q + 1'b1;
      else if (healthy) oc_cnt_q <= '0;
      if (uv_ev)        uv_cnt_q <= (uv_cnt_q == TOP) ? TOP : uv_cnt_q + 1'b1;
      else if (healthy) uv_cnt_q <= '0;
    end
  end

  assign discharge_o = oc_ret_q | uv_ret_q;
  assign inhibit_o   = oc_ret_q | uv_ret_q | shut_q;
  assign shutdown_o  = shut_q;
  assign oc_retry_o  = oc_ret_q;
  assign uv_retry_o  = uv_ret_q;
  assign oc_count_o  = oc_cnt_q;
  assign uv_count_o  = uv_cnt_q;

  p_shutdown_sticky_r8: assert property (@(posedge clk) disable iff (por_i)
    shutdown_o |=> shutdown_o);

  p_inhibit_in_shutdown_r8: assert property (@(posedge clk) disable iff (por_i)
    shutdown_o |-> inhibit_o);

  p_oc_step_r3: assert property (@(posedge clk) disable iff (por_i)
    (oc_count_o != $past(oc_count_o)) |-> (oc_count_o == '0 || oc_count_o == $past(oc_count_o) + 1'b1));

  p_uv_step_r4: assert property (@(posedge clk) disable iff (por_i)
    (uv_count_o != $past(uv_count_o)) |-> (uv_count_o == '0 || uv_count_o == $past(uv_count_o) + 1'b1));

  p_limit_shutdown_r5: assert property (@(posedge clk) disable iff (por_i)
    (oc_count_o == TOP || uv_count_o == TOP) |-> shutdown_o);

  p_retry_release_r6: assert property (@(posedge clk) disable iff (por_i)
    ($fell(oc_retry_o) || $fell(uv_retry_o)) |-> $past(b_low));

  p_uv4_masked_r2: assert property (@(posedge clk) disable iff (por_i)
    $rose(shutdown_o) |-> $past(ov_s || (s[4] && b_up) || oc_ev || uv_ev));
endmodule

// File: tb/rail_fault_supervisor_test.sv
module rail_fault_supervisor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_i, ov1_i, oc1_i, uv2_i, uv3_i, uv4_i, grp_a_up_i, grp_b_up_i, grp_b_low_i;
  logic inhibit_o, discharge_o, shutdown_o, oc_retry_o, uv_retry_o;
  logic [1:0] oc_count_o, uv_count_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_supervisor uut (
    .clk(clk), .por_i(por_i), .ov1_i(ov1_i), .oc1_i(oc1_i), .uv2_i(uv2_i),
    .uv3_i(uv3_i), .uv4_i(uv4_i), .grp_a_up_i(grp_a_up_i), .grp_b_up_i(grp_b_up_i),
    .grp_b_low_i(grp_b_low_i), .inhibit_o(inhibit_o), .discharge_o(discharge_o),
    .shutdown_o(shutdown_o), .oc_retry_o(oc_retry_o), .uv_retry_o(uv_retry_o),
    .oc_count_o(oc_count_o), .uv_count_o(uv_count_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic healthy_inputs();
    ov1_i = 0; oc1_i = 0; uv2_i = 0; uv3_i = 0; uv4_i = 0;
    grp_a_up_i = 1; grp_b_up_i = 1; grp_b_low_i = 0;
  endtask

  task automatic do_por();
    por_i = 1; tick(2);
    chk("R9 shutdown", shutdown_o, 0);
    chk("R9 inhibit", inhibit_o, 0);
    chk("R9 counts", {oc_count_o, uv_count_o}, 0);
    por_i = 0; tick(6);
  endtask

  task automatic discharge_cycle();
    grp_a_up_i = 0; grp_b_up_i = 0; grp_b_low_i = 1; tick(4);
    grp_b_low_i = 0; tick(1);
  endtask

  task automatic t_reset();
    healthy_inputs();
    do_por();
    chk("R9 idle inhibit", inhibit_o, 0);
    chk("R9 idle retry", {oc_retry_o, uv_retry_o}, 0);
  endtask

  task automatic t_ov();
    ov1_i = 1; tick(2);
    chk("R1 latency", shutdown_o, 0);
    tick(1);
    chk("R1 shutdown", shutdown_o, 1);
    chk("R1 inhibit", inhibit_o, 1);
    chk("R1 no retry", oc_retry_o, 0);
    ov1_i = 0; grp_b_low_i = 1; tick(4);
    chk("R8 held", shutdown_o, 1);
    chk("R8 inhibit held", inhibit_o, 1);
    healthy_inputs(); tick(4);
    chk("R8 held healthy", shutdown_o, 1);
    do_por();
  endtask

  task automatic t_uv4_mask();
    grp_b_up_i = 0; uv4_i = 1; tick(6);
    chk("R2 masked", shutdown_o, 0);
    chk("R2 masked inhibit", inhibit_o, 0);
    grp_b_up_i = 1; tick(4);
    chk("R2 shutdown", shutdown_o, 1);
    chk("R2 no retry", uv_retry_o, 0);
    healthy_inputs(); do_por();
  endtask

  task automatic t_oc_retry();
    oc1_i = 1; tick(1); oc1_i = 0; tick(2);
    chk("R3 retry", oc_retry_o, 1);
    chk("R3 inhibit", inhibit_o, 1);
    chk("R3 discharge", discharge_o, 1);
    chk("R3 count", oc_count_o, 1);
    tick(5);
    chk("R6 held without low", oc_retry_o, 1);
    discharge_cycle();
    chk("R6 released", oc_retry_o, 0);
    chk("R6 inhibit off", inhibit_o, 0);
    chk("R6 count kept", oc_count_o, 1);
    grp_a_up_i = 1; grp_b_up_i = 1; tick(5);
    chk("R7 cleared", oc_count_o, 0);
  endtask

  task automatic t_uv_mask();
    grp_b_up_i = 0; uv2_i = 1; tick(6);
    chk("R4 uv2 masked", uv_retry_o, 0);
    uv2_i = 0; grp_b_up_i = 1;
    grp_a_up_i = 0; uv3_i = 1; tick(6);
    chk("R4 uv3 masked", {uv_retry_o, uv_count_o}, 0);
    uv3_i = 0; grp_a_up_i = 1; tick(4);
    uv3_i = 1; tick(1); uv3_i = 0; tick(4);
    chk("R4 uv3 retry", uv_retry_o, 1);
    chk("R4 uv count", uv_count_o, 1);
    chk("R4 oc untouched", oc_count_o, 0);
    discharge_cycle();
    grp_a_up_i = 1; grp_b_up_i = 1; tick(5);
    chk("R7 uv cleared", uv_count_o, 0);
  endtask

  task automatic t_three();
    for (int i = 1; i <= 3; i++) begin
      uv2_i = 1; tick(1); uv2_i = 0; tick(4);
      chk("R5 count step", uv_count_o, i);
      chk("R5 shutdown", shutdown_o, (i == 3) ? 1 : 0);
      discharge_cycle();
      grp_a_up_i = 1; grp_b_up_i = 1;
    end
    tick(4);
    chk("R5 saturate kept", uv_count_o, 3);
    do_por();
  endtask

  task automatic t_held_once();
    oc1_i = 1; tick(20);
    chk("R10 single count", oc_count_o, 1);
    oc1_i = 0; tick(4);
    chk("R10 no extra", oc_count_o, 1);
    do_por();
  endtask

  initial begin
    t_reset();
    t_ov();
    t_uv4_mask();
    t_oc_retry();
    t_uv_mask();
    t_three();
    t_held_once();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule